// File: doc/BRIEF.md
# High/Low Class Candidate Merger

This block takes the two leading track candidates from a high-pT selection path and the two from a low-pT path, and reduces them to one final ordered pair. Candidates are ranked first by class: any valid high-pT candidate outranks every low-pT one. Transverse momentum only decides the order among candidates of the same class. Each output word carries a class flag, so the receiver knows which path the candidate came from.

A candidate is a 10-bit word with these fields:

- bit 9 is the class flag.
- bits 8:6 are the hit id. An id of 0 means no hit.
- bit 5 is the position.
- bit 4 is the sign.
- bits 3:0 are the pT magnitude.

The block drives the class flag itself from the path a candidate entered on. Whatever arrives in bit 9 of an input is overwritten. Both outputs are registered, with one cycle of latency.

Top module: `hl_cand_merge`

## Requirements
- R1: When both high-pT inputs hold valid hits, both outputs are high-pT candidates, whatever the low path holds.
- R2: When exactly one high-pT input holds a valid hit, output A is that candidate and output B is the best valid low-pT candidate, or no hit if there is none.
- R3: When neither high-pT input is valid, both outputs are taken from the valid low-pT candidates in ranked order.
- R4: Within one class, the candidate with the larger pT magnitude (bits 3:0) comes first. On equal pT, the candidate that arrived on the primary input of its path comes first.
- R5: Output bit 9 is 1 for a candidate from the high-pT path and 0 for one from the low-pT path, independent of the incoming bit 9.
- R6: A candidate whose hit id (bits 8:6) is 0 is skipped. An output left without a candidate is driven as all zeros, and output B is never valid while output A is empty.
- R7: Outputs are all zeros while rst_n is low. An input set presented before a rising clock edge appears on the outputs after that edge.
- R8: The hit id, position, sign and pT fields of a selected candidate reach the output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_pri_i | input | 10 | High-pT path, primary candidate |
| hi_sec_i | input | 10 | High-pT path, secondary candidate |
| lo_pri_i | input | 10 | Low-pT path, primary candidate |
| lo_sec_i | input | 10 | Low-pT path, secondary candidate |
| out_a_o | output | 10 | Final first candidate (registered) |
| out_b_o | output | 10 | Final second candidate (registered) |

## Verification
Every result is due exactly one rising edge after its inputs are applied. The bench therefore drives each input set on a falling edge and compares both outputs at the next falling edge. The comparison uses an expectation that a scoring model computed from that same input set. The model ranks by class, then pT, then primary-before-secondary, and picks the top two valid entries. It shares no structure with the path-sorting and merging logic. Directed sets cover equal-pT ties, lone secondaries, empty paths and a forged class bit. A long randomized run then compares on every clock.

// File: rtl/hl_merge_pkg.sv
package hl_merge_pkg;
    parameter int ID_W = 3;
    parameter int PT_W = 4;
    localparam int CAND_W = 1 + ID_W + 2 + PT_W;

    typedef struct packed {
        logic            cls;
        logic [ID_W-1:0] id;
        logic            pos;
        logic            sgn;
        logic [PT_W-1:0] pt;
    } cand_t;

    function automatic logic is_hit(input cand_t c);
        return c.id != '0;
    endfunction
endpackage

// File: rtl/hl_path_order.sv
module hl_path_order
    import hl_merge_pkg::*;
#(
    parameter logic CLS = 1'b1
) (
    input  cand_t pri_i,
    input  cand_t sec_i,
    output cand_t first_o,
    output cand_t second_o
);
    cand_t pri_t, sec_t;

    always_comb begin
        pri_t     = pri_i;
        pri_t.cls = CLS;
        sec_t     = sec_i;
        sec_t.cls = CLS;
        first_o   = '0;
        second_o  = '0;
        if (is_hit(pri_i) && is_hit(sec_i)) begin
            if (sec_i.pt > pri_i.pt) begin
                first_o  = sec_t;
                second_o = pri_t;
            end else begin
                first_o  = pri_t;
                second_o = sec_t;
            end
        end else if (is_hit(pri_i)) begin
            first_o = pri_t;
        end else if (is_hit(sec_i)) begin
            first_o = sec_t;
        end
    end
endmodule

// File: rtl/hl_pair_merge.sv
module hl_pair_merge
    import hl_merge_pkg::*;
(
    input  cand_t hi_first_i,
    input  cand_t hi_second_i,
    input  cand_t lo_first_i,
    input  cand_t lo_second_i,
    output cand_t a_o,
    output cand_t b_o
);
    always_comb begin
        if (is_hit(hi_first_i)) begin
            a_o = hi_first_i;
            b_o = is_hit(hi_second_i) ? hi_second_i : lo_first_i;
        end else begin
            a_o = lo_first_i;
            b_o = lo_second_i;
        end
    end
endmodule

// File: rtl/hl_cand_merge.sv
module hl_cand_merge
    import hl_merge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CAND_W-1:0] hi_pri_i,
    input  logic [CAND_W-1:0] hi_sec_i,
    input  logic [CAND_W-1:0] lo_pri_i,
    input  logic [CAND_W-1:0] lo_sec_i,
    output logic [CAND_W-1:0] out_a_o,
    output logic [CAND_W-1:0] out_b_o
);
    localparam int NPATH = 2;

    typedef struct packed {
        cand_t a;
        cand_t b;
        logic  live;
    } out_state_t;

    cand_t pri_in   [NPATH];
    cand_t sec_in   [NPATH];
    cand_t first_w  [NPATH];
    cand_t second_w [NPATH];
    cand_t merge_a, merge_b;
    out_state_t st_d, st_q;

    assign pri_in[0] = cand_t'(hi_pri_i);
    assign sec_in[0] = cand_t'(hi_sec_i);
    assign pri_in[1] = cand_t'(lo_pri_i);
    assign sec_in[1] = cand_t'(lo_sec_i);

    for (genvar g = 0; g < NPATH; g++) begin : g_path
        hl_path_order #(.CLS(g == 0 ? 1'b1 : 1'b0)) u_order (
            .pri_i   (pri_in[g]),
            .sec_i   (sec_in[g]),
            .first_o (first_w[g]),
            .second_o(second_w[g])
        );
    end

    hl_pair_merge u_merge (
        .hi_first_i (first_w[0]),
        .hi_second_i(second_w[0]),
        .lo_first_i (first_w[1]),
        .lo_second_i(second_w[1]),
        .a_o        (merge_a),
        .b_o        (merge_b)
    );

    always_comb begin
        st_d      = st_q;
        st_d.a    = merge_a;
        st_d.b    = merge_b;
        st_d.live = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_a_o = st_q.a;
    assign out_b_o = st_q.b;

    cand_t oa, ob;
    assign oa = cand_t'(out_a_o);
    assign ob = cand_t'(out_b_o);

    AST_B_NEEDS_A: assert property (@(posedge clk) disable iff (!rst_n)
        is_hit(ob) |-> is_hit(oa)); // R6

    AST_CLASS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (is_hit(oa) && is_hit(ob)) |-> (oa.cls >= ob.cls)); // R1

    AST_PT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (is_hit(oa) && is_hit(ob) && oa.cls == ob.cls) |-> (oa.pt >= ob.pt)); // R4

    AST_HIGH_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.live && $past(hi_pri_i[CAND_W-2 -: ID_W] != '0)) |-> (is_hit(oa) && oa.cls)); // R2

    AST_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.live && is_hit(oa) && !oa.cls) |->
        ($past(hi_pri_i[CAND_W-2 -: ID_W] == '0) && $past(hi_sec_i[CAND_W-2 -: ID_W] == '0))); // R3

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (out_a_o == '0 && out_b_o == '0)); // R7
endmodule

// File: tb/tb_hl_cand_merge.sv
module tb_hl_cand_merge;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] hp = '0, hs = '0, lp = '0, ls = '0;
    logic [9:0] out_a, out_b;
    logic [19:0] exp_pair;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    hl_cand_merge dut (
        .clk(clk), .rst_n(rst_n),
        .hi_pri_i(hp), .hi_sec_i(hs), .lo_pri_i(lp), .lo_sec_i(ls),
        .out_a_o(out_a), .out_b_o(out_b)
    );

    function automatic logic [19:0] model(input logic [9:0] a, b, c, d);
        logic [9:0] w [4];
        int score [4];
        int best1, best2;
        logic [9:0] r1, r2;
        w[0] = a; w[1] = b; w[2] = c; w[3] = d;
        for (int i = 0; i < 4; i++) begin
            if (w[i][8:6] == 0) score[i] = -1;
            else score[i] = ((i < 2) ? 64 : 0) + 2 * int'(w[i][3:0]) + ((i % 2 == 0) ? 1 : 0);
        end
        best1 = 0;
        for (int i = 1; i < 4; i++) if (score[i] > score[best1]) best1 = i;
        best2 = (best1 == 0) ? 1 : 0;
        for (int i = 0; i < 4; i++) if (i != best1 && score[i] > score[best2]) best2 = i;
        r1 = (score[best1] < 0) ? 10'd0 : {(best1 < 2) ? 1'b1 : 1'b0, w[best1][8:0]};
        r2 = (score[best2] < 0) ? 10'd0 : {(best2 < 2) ? 1'b1 : 1'b0, w[best2][8:0]};
        return {r1, r2};
    endfunction

    function automatic logic [9:0] mk(input bit c, input int id, input bit pos, input bit sg, input int pt);
        return {c, 3'(id), pos, sg, 4'(pt)};
    endfunction

    task automatic check(input string tag);
        checks++;
        if ({out_a, out_b} !== exp_pair) begin
            errors++;
            $display("FAIL %s: got a=%h b=%h expected a=%h b=%h", tag, out_a, out_b,
                     exp_pair[19:10], exp_pair[9:0]);
        end
    endtask

    // apply on negedge, compare at following negedge
    task automatic step(input logic [9:0] a, b, c, d, input string tag);
        hp = a; hs = b; lp = c; ls = d;
        exp_pair = model(a, b, c, d);
        @(negedge clk);
        check(tag);
    endtask

    function automatic string scen_tag(input logic [9:0] a, b, c, d);
        int nh;
        nh = (a[8:6] != 0 ? 1 : 0) + (b[8:6] != 0 ? 1 : 0);
        if (nh == 2) return "R1";
        if (nh == 1) return "R2";
        if (c[8:6] != 0 || d[8:6] != 0) return "R3";
        return "R6";
    endfunction

    function automatic logic [9:0] rnd();
        int id;
        id = ($urandom % 3 == 0) ? 0 : int'($urandom % 7) + 1;
        return {1'($urandom), 3'(id), 1'($urandom), 1'($urandom), 4'($urandom)};
    endfunction

    initial begin
        #200000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [9:0] a, b, c, d;
        exp_pair = '0;
        repeat (3) @(negedge clk);
        check("R7 reset");
        hp = mk(1, 3, 0, 0, 9);
        @(negedge clk);
        check("R7 held in reset");
        rst_n = 1'b1;
        hp = '0;
        @(negedge clk);
        step(mk(0,5,1,0,7), mk(0,2,0,1,3), mk(0,1,0,0,15), mk(0,6,1,1,14), "R1 R5 two high");
        step(mk(0,4,1,1,2), '0, mk(1,3,0,0,12), mk(1,7,1,0,10), "R2 one high");
        step('0, mk(0,6,0,1,5), '0, '0, "R2 lone secondary high");
        step('0, '0, mk(1,2,0,1,4), mk(1,3,1,0,11), "R3 low swap");
        step(mk(1,2,0,0,8), mk(1,5,1,1,8), '0, '0, "R4 tie high");
        step('0, '0, mk(0,7,0,0,6), mk(0,1,1,1,6), "R4 tie low");
        step(mk(1,0,1,1,15), mk(1,0,0,1,9), mk(1,0,1,0,3), mk(0,0,1,1,1), "R6 all empty");
        step('0, '0, '0, mk(1,4,1,0,2), "R6 lone low secondary");
        step(mk(0,7,1,1,15), '0, '0, '0, "R8 fields");
        step(mk(0,1,0,0,0), mk(1,1,1,1,0), mk(1,7,1,1,15), '0, "R5 forged class");
        for (int i = 0; i < 2000; i++) begin
            a = rnd(); b = rnd(); c = rnd(); d = rnd();
            step(a, b, c, d, scen_tag(a, b, c, d));
        end
        rst_n = 1'b0;
        exp_pair = '0;
        #1;
        check("R7 async reset");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule